// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Forwarding Control

This block controls data hazards in a five-stage in-order RV32I integer pipeline with fetch, decode, execute, memory and writeback stages. It looks at the full instruction word that sits in decode. For each of the three later stages it also takes the major opcode and the destination register field that the stage holds. From these it works out which registers the decode instruction really reads and which later stage will really write a register. It then drives a stall, a bubble request and one forwarding select for each of the two ALU operands.

The surrounding datapath uses the outputs as follows. When stall is high, it holds the fetch and decode registers and loads a nop into execute. The held instruction is evaluated again in the next cycle. Each operand multiplexer takes the register-file value, the result of a later stage, or the return address (pc+4) of a jump that sits in a later stage.

A compile-time parameter picks one of two modes. The forwarding mode stalls only on a load-use dependence. The interlock mode has no forwarding paths and stalls on any dependence that is still in flight. The block holds no state: all outputs are a pure function of the present inputs.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: A later-stage instruction counts as a register writer only when its opcode is OP (0110011), OP-IMM (0010011), LOAD (0000011), LUI (0110111), AUIPC (0010111), JAL (1101111) or JALR (1100111) and its destination field is nonzero. STORE (0100011), BRANCH (1100011) and any other opcode never write, whatever bits 11:7 hold.
- R2: The first source, decode bits 19:15, is read only for OP, OP-IMM, LOAD, STORE, BRANCH and JALR. A match on those bits for LUI, AUIPC or JAL has no effect.
- R3: The second source, decode bits 24:20, is read only for OP, STORE and BRANCH. A match on those bits for OP-IMM, LOAD or JALR has no effect.
- R4: In forwarding mode each operand select gives the youngest writer that matches a read source. The code values are 0 register file, 1 execute result, 3 memory result and 5 writeback result. Execute has priority over memory, and memory has priority over writeback.
- R5: In forwarding mode stall is 1 exactly when a LOAD in execute writes a register that the decode instruction reads. During that stall both selects are 0. A load that has reached memory or writeback is forwarded without a stall.
- R6: When the matching writer is JAL or JALR, the select takes the return-address code instead of the result code: 2 for execute, 4 for memory, 6 for writeback.
- R7: In interlock mode stall is 1 whenever a read source matches the destination of a writer in execute, memory or writeback. In this mode both selects are always 0.
- R8: bubble always equals stall. A decode instruction that reads no register, including one with an unknown opcode, never stalls.
- R9: Register 0 is never forwarded and never causes a stall, even when a later stage names it as its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_instr | input | 32 | Instruction word held in decode |
| ex_opcode | input | 7 | Major opcode of the instruction in execute |
| ex_rd | input | 5 | Destination field of the instruction in execute |
| mem_opcode | input | 7 | Major opcode of the instruction in memory |
| mem_rd | input | 5 | Destination field of the instruction in memory |
| wb_opcode | input | 7 | Major opcode of the instruction in writeback |
| wb_rd | input | 5 | Destination field of the instruction in writeback |
| stall | output | 1 | Hold fetch and decode this cycle |
| bubble | output | 1 | Load a nop into execute this cycle |
| fwd_a_sel | output | 3 | Source select for ALU operand A |
| fwd_b_sel | output | 3 | Source select for ALU operand B |

## Verification
The bench builds two instances side by side and drives both with the same inputs. The first is built with BYPASS_EN=1 and the second with BYPASS_EN=0. The forwarding instance covers stage priority, the return-address paths and the load-use stall. The interlock instance shows which dependences become stalls when there are no forwarding paths. Driving the two modes together exposes any mix-up in the variant chosen by the parameter, since the same dependence must give different outputs in each mode.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OP_IMM = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [2:0] {
    SEL_RF       = 3'd0,
    SEL_EX_RES   = 3'd1,
    SEL_EX_LINK  = 3'd2,
    SEL_MEM_RES  = 3'd3,
    SEL_MEM_LINK = 3'd4,
    SEL_WB_RES   = 3'd5,
    SEL_WB_LINK  = 3'd6
  } fwd_sel_e;

  // opcode classes that put a value into rd
  function automatic logic op_writes(input logic [6:0] op);
    return (op == OPC_OP) || (op == OPC_OP_IMM) || (op == OPC_LOAD) ||
           (op == OPC_LUI) || (op == OPC_AUIPC) || (op == OPC_JAL) ||
           (op == OPC_JALR);
  endfunction

  function automatic logic op_reads_a(input logic [6:0] op);
    return (op == OPC_OP) || (op == OPC_OP_IMM) || (op == OPC_LOAD) ||
           (op == OPC_STORE) || (op == OPC_BRANCH) || (op == OPC_JALR);
  endfunction

  function automatic logic op_reads_b(input logic [6:0] op);
    return (op == OPC_OP) || (op == OPC_STORE) || (op == OPC_BRANCH);
  endfunction

  function automatic logic op_is_link(input logic [6:0] op);
    return (op == OPC_JAL) || (op == OPC_JALR);
  endfunction

  // value is ready at the end of execute (everything but a load)
  function automatic logic op_ready_in_ex(input logic [6:0] op);
    return op_writes(op) && (op != OPC_LOAD);
  endfunction

endpackage

// File: rtl/hzd_src_decode.sv
module hzd_src_decode #(
  parameter int REG_AW = 5
) (
  input  logic [6:0]        opcode,
  input  logic [REG_AW-1:0] rs1_fld,
  input  logic [REG_AW-1:0] rs2_fld,
  output logic              rd_a_en,
  output logic              rd_b_en,
  output logic [REG_AW-1:0] rs_a,
  output logic [REG_AW-1:0] rs_b
);
  import hzd_pkg::*;

  assign rd_a_en = op_reads_a(opcode);
  assign rd_b_en = op_reads_b(opcode);
  assign rs_a    = rs1_fld;
  assign rs_b    = rs2_fld;

  always_comb begin
    if (opcode == OPC_LUI || opcode == OPC_JAL || opcode == OPC_AUIPC)
      p_no_src_for_upper_r2: assert (!rd_a_en && !rd_b_en);
  end
endmodule

// File: rtl/hzd_dst_decode.sv
module hzd_dst_decode #(
  parameter int REG_AW = 5
) (
  input  logic [6:0]        opcode,
  input  logic [REG_AW-1:0] rd_fld,
  output logic              wr_en,
  output logic              link,
  output logic              is_load,
  output logic              ready_ex
);
  import hzd_pkg::*;

  logic rd_nonzero;
  assign rd_nonzero = |rd_fld;
  assign wr_en      = op_writes(opcode) && rd_nonzero;
  assign link       = op_is_link(opcode);
  assign is_load    = (opcode == OPC_LOAD);
  assign ready_ex   = op_ready_in_ex(opcode);

  always_comb begin
    if (opcode == OPC_STORE || opcode == OPC_BRANCH)
      p_no_write_store_branch_r1: assert (!wr_en);
  end
endmodule

// File: rtl/hzd_operand_fwd.sv
module hzd_operand_fwd #(
  parameter int REG_AW    = 5,
  parameter int NSTG      = 3,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic                       rd_en,
  input  logic [REG_AW-1:0]          rs,
  input  logic [NSTG-1:0]            st_wr,
  input  logic [NSTG-1:0]            st_link,
  input  logic [NSTG-1:0][REG_AW-1:0] st_rd,
  input  logic                       ex_load,
  input  logic                       ex_ready,
  output hzd_pkg::fwd_sel_e          sel,
  output logic                       stall_req
);
  import hzd_pkg::*;

  localparam int ST_EX  = 0;
  localparam int ST_MEM = 1;
  localparam int ST_WB  = 2;

  logic [NSTG-1:0] hit;

  for (genvar g = 0; g < NSTG; g++) begin : g_hit
    assign hit[g] = rd_en && st_wr[g] && (st_rd[g] == rs);
  end

  if (BYPASS_EN) begin : g_bypass
    always_comb begin
      sel       = SEL_RF;
      stall_req = 1'b0;
      if (hit[ST_EX]) begin
        if (ex_load || !ex_ready) stall_req = 1'b1;
        else sel = st_link[ST_EX] ? SEL_EX_LINK : SEL_EX_RES;
      end else if (hit[ST_MEM]) begin
        sel = st_link[ST_MEM] ? SEL_MEM_LINK : SEL_MEM_RES;
      end else if (hit[ST_WB]) begin
        sel = st_link[ST_WB] ? SEL_WB_LINK : SEL_WB_RES;
      end
    end
  end else begin : g_interlock
    logic unused_ex;
    assign unused_ex = ex_load ^ ex_ready ^ (|st_link);
    always_comb begin
      sel       = SEL_RF;
      stall_req = |hit;
    end
  end

  always_comb begin
    if (sel != SEL_RF) p_sel_needs_read_r4: assert (rd_en && rs != '0);
    if (sel == SEL_EX_RES || sel == SEL_EX_LINK)
      p_ex_sel_has_hit_r4: assert (hit[ST_EX] && !ex_load);
    if (sel == SEL_MEM_RES || sel == SEL_MEM_LINK)
      p_mem_sel_not_younger_r4: assert (!hit[ST_EX] && hit[ST_MEM]);
    if (!BYPASS_EN) p_interlock_rf_only_r7: assert (sel == SEL_RF);
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
  parameter int ILEN      = 32,
  parameter int REG_AW    = 5,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic [ILEN-1:0]   dec_instr,
  input  logic [6:0]        ex_opcode,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic [6:0]        mem_opcode,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic [6:0]        wb_opcode,
  input  logic [REG_AW-1:0] wb_rd,
  output logic              stall,
  output logic              bubble,
  output logic [2:0]        fwd_a_sel,
  output logic [2:0]        fwd_b_sel
);
  import hzd_pkg::*;

  localparam int NSTG   = 3;
  localparam int RS1_LO = 15;
  localparam int RS2_LO = 20;

  logic unused_instr;
  assign unused_instr = ^{dec_instr[ILEN-1:RS2_LO+REG_AW], dec_instr[RS1_LO-1:7]};

  // decode-stage source side
  logic              re_a, re_b;
  logic [REG_AW-1:0] rs_a, rs_b;

  hzd_src_decode #(.REG_AW(REG_AW)) u_src (
    .opcode  (dec_instr[6:0]),
    .rs1_fld (dec_instr[RS1_LO +: REG_AW]),
    .rs2_fld (dec_instr[RS2_LO +: REG_AW]),
    .rd_a_en (re_a),
    .rd_b_en (re_b),
    .rs_a    (rs_a),
    .rs_b    (rs_b)
  );

  // later-stage destination side: index 0 execute, 1 memory, 2 writeback
  logic [NSTG-1:0][6:0]        st_op;
  logic [NSTG-1:0][REG_AW-1:0] st_rd;
  logic [NSTG-1:0]             st_wr, st_link, st_load, st_ready;

  assign st_op = {wb_opcode, mem_opcode, ex_opcode};
  assign st_rd = {wb_rd, mem_rd, ex_rd};

  for (genvar s = 0; s < NSTG; s++) begin : g_dst
    hzd_dst_decode #(.REG_AW(REG_AW)) u_dst (
      .opcode   (st_op[s]),
      .rd_fld   (st_rd[s]),
      .wr_en    (st_wr[s]),
      .link     (st_link[s]),
      .is_load  (st_load[s]),
      .ready_ex (st_ready[s])
    );
  end

  logic unused_late;
  assign unused_late = ^{st_load[NSTG-1:1], st_ready[NSTG-1:1]};

  fwd_sel_e sel_a, sel_b;
  logic     stall_a, stall_b;

  hzd_operand_fwd #(.REG_AW(REG_AW), .NSTG(NSTG), .BYPASS_EN(BYPASS_EN)) u_fwd_a (
    .rd_en (re_a), .rs (rs_a), .st_wr (st_wr), .st_link (st_link), .st_rd (st_rd),
    .ex_load (st_load[0]), .ex_ready (st_ready[0]), .sel (sel_a), .stall_req (stall_a)
  );

  hzd_operand_fwd #(.REG_AW(REG_AW), .NSTG(NSTG), .BYPASS_EN(BYPASS_EN)) u_fwd_b (
    .rd_en (re_b), .rs (rs_b), .st_wr (st_wr), .st_link (st_link), .st_rd (st_rd),
    .ex_load (st_load[0]), .ex_ready (st_ready[0]), .sel (sel_b), .stall_req (stall_b)
  );

  logic hazard;
  assign hazard    = stall_a | stall_b;
  assign stall     = hazard;
  assign bubble    = hazard;
  // a held instruction must not also steer operands from later stages
  assign fwd_a_sel = hazard ? SEL_RF : sel_a;
  assign fwd_b_sel = hazard ? SEL_RF : sel_b;

  always_comb begin
    if (BYPASS_EN && stall) p_stall_only_on_load_r5: assert (st_load[0] && st_wr[0]);
    if (!re_a && !re_b) p_no_read_no_stall_r8: assert (!stall);
    if (stall) p_stall_selects_rf_r5: assert (fwd_a_sel == 3'd0 && fwd_b_sel == 3'd0);
    if (st_rd[0] == '0) p_x0_never_writes_r9: assert (!st_wr[0]);
  end
endmodule

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb_top;
  localparam logic [6:0] T_OP = 7'b0110011, T_OPI = 7'b0010011, T_LD = 7'b0000011,
                         T_ST = 7'b0100011, T_BR = 7'b1100011, T_LUI = 7'b0110111,
                         T_AUI = 7'b0010111, T_JAL = 7'b1101111, T_JALR = 7'b1100111,
                         T_BAD = 7'b1111111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr = '0;
  logic [6:0]  eop = '0, mop = '0, wop = '0;
  logic [4:0]  erd = '0, mrd = '0, wrd = '0;
  logic        st_f, bb_f, st_i, bb_i;
  logic [2:0]  a_f, b_f, a_i, b_i;
  int n_chk = 0, n_bad = 0;

  pipe_hazard_ctrl #(.BYPASS_EN(1'b1)) dut_i (
    .dec_instr(instr), .ex_opcode(eop), .ex_rd(erd), .mem_opcode(mop), .mem_rd(mrd),
    .wb_opcode(wop), .wb_rd(wrd), .stall(st_f), .bubble(bb_f), .fwd_a_sel(a_f), .fwd_b_sel(b_f));

  pipe_hazard_ctrl #(.BYPASS_EN(1'b0)) dut_il (
    .dec_instr(instr), .ex_opcode(eop), .ex_rd(erd), .mem_opcode(mop), .mem_rd(mrd),
    .wb_opcode(wop), .wb_rd(wrd), .stall(st_i), .bubble(bb_i), .fwd_a_sel(a_i), .fwd_b_sel(b_i));

  function automatic logic [31:0] ins(input logic [6:0] op, input logic [4:0] r1, input logic [4:0] r2);
    return {7'b0, r2, r1, 3'b0, 5'd9, op};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] i, input logic [6:0] eo, input logic [4:0] er,
                       input logic [6:0] mo, input logic [4:0] mr,
                       input logic [6:0] wo, input logic [4:0] wr);
    @(negedge clk);
    instr = i; eop = eo; erd = er; mop = mo; mrd = mr; wop = wo; wrd = wr;
    #1;
  endtask

  task automatic t_reset;
    drive('0, '0, '0, '0, '0, '0, '0);
    chk("R8", "idle stall", st_f, 0);
    chk("R8", "idle stall il", st_i, 0);
    chk("R4", "idle sel a", a_f, 0);
    chk("R4", "idle sel b", b_f, 0);
  endtask

  task automatic t_priority;
    drive(ins(T_OP, 5'd3, 5'd3), T_OP, 5'd3, T_OP, 5'd3, T_OP, 5'd3);
    chk("R4", "ex first a", a_f, 1);
    chk("R4", "ex first b", b_f, 1);
    chk("R4", "ex no stall", st_f, 0);
    chk("R7", "interlock stall", st_i, 1);
    chk("R7", "interlock sel a", a_i, 0);
    drive(ins(T_OP, 5'd3, 5'd3), T_OP, 5'd9, T_OP, 5'd3, T_OP, 5'd3);
    chk("R4", "mem over wb", a_f, 3);
    drive(ins(T_OP, 5'd3, 5'd3), T_OP, 5'd9, T_OP, 5'd9, T_OP, 5'd3);
    chk("R4", "wb only", b_f, 5);
  endtask

  task automatic t_load_use;
    drive(ins(T_OP, 5'd4, 5'd1), T_LD, 5'd4, '0, '0, '0, '0);
    chk("R5", "load use a stall", st_f, 1);
    chk("R8", "bubble tracks", bb_f, 1);
    chk("R5", "sel rf in stall", a_f, 0);
    drive(ins(T_OP, 5'd1, 5'd4), T_LD, 5'd4, '0, '0, '0, '0);
    chk("R5", "load use b stall", st_f, 1);
    drive(ins(T_LUI, 5'd4, 5'd4), T_LD, 5'd4, '0, '0, '0, '0);
    chk("R2", "lui no read", st_f, 0);
    drive(ins(T_AUI, 5'd4, 5'd0), T_LD, 5'd4, '0, '0, '0, '0);
    chk("R2", "auipc no read", st_f, 0);
    drive(ins(T_OPI, 5'd1, 5'd4), T_LD, 5'd4, '0, '0, '0, '0);
    chk("R3", "op-imm no rs2", st_f, 0);
    drive(ins(T_JALR, 5'd1, 5'd4), T_LD, 5'd4, '0, '0, '0, '0);
    chk("R3", "jalr no rs2", st_f, 0);
    drive(ins(T_OP, 5'd4, 5'd1), T_OP, 5'd7, T_LD, 5'd4, '0, '0);
    chk("R5", "load in mem no stall", st_f, 0);
    chk("R5", "load in mem fwd", a_f, 3);
  endtask

  task automatic t_link;
    drive(ins(T_JALR, 5'd1, 5'd0), T_JAL, 5'd1, '0, '0, '0, '0);
    chk("R6", "ex link", a_f, 2);
    drive(ins(T_JALR, 5'd1, 5'd0), '0, '0, T_JALR, 5'd1, '0, '0);
    chk("R6", "mem link", a_f, 4);
    drive(ins(T_BR, 5'd0, 5'd1), '0, '0, '0, '0, T_JAL, 5'd1);
    chk("R6", "wb link b", b_f, 6);
  endtask

  task automatic t_zero_and_nonwriters;
    drive(ins(T_OP, 5'd0, 5'd0), T_LD, 5'd0, T_OP, 5'd0, '0, '0);
    chk("R9", "x0 no stall", st_f, 0);
    chk("R9", "x0 no fwd", a_f, 0);
    chk("R9", "x0 interlock", st_i, 0);
    drive(ins(T_OP, 5'd5, 5'd0), T_ST, 5'd5, T_BR, 5'd5, T_BAD, 5'd5);
    chk("R1", "store/branch/unknown not writers", a_f, 0);
    chk("R1", "no interlock on non-writers", st_i, 0);
    drive(ins(T_OP, 5'd5, 5'd0), T_LUI, 5'd5, '0, '0, '0, '0);
    chk("R1", "lui writes", a_f, 1);
    drive(ins(T_OP, 5'd5, 5'd0), T_AUI, 5'd5, '0, '0, '0, '0);
    chk("R1", "auipc writes", a_f, 1);
  endtask

  task automatic t_unknown_decode;
    drive(ins(T_BAD, 5'd6, 5'd6), T_LD, 5'd6, T_OP, 5'd6, T_OP, 5'd6);
    chk("R8", "unknown no stall", st_f, 0);
    chk("R8", "unknown no stall il", bb_i, 0);
    chk("R8", "unknown sel", a_f, 0);
  endtask

  task automatic t_store_and_interlock;
    drive(ins(T_ST, 5'd1, 5'd6), '0, '0, '0, '0, T_LD, 5'd6);
    chk("R3", "store rs2 wb", b_f, 5);
    chk("R7", "il store stalls", st_i, 1);
    drive(ins(T_BR, 5'd0, 5'd2), '0, '0, T_OPI, 5'd2, '0, '0);
    chk("R7", "il branch stall", st_i, 1);
    chk("R8", "il bubble", bb_i, 1);
    chk("R4", "branch mem fwd", b_f, 3);
    chk("R7", "il sel b rf", b_i, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_priority();
    t_load_use();
    t_link();
    t_zero_and_nonwriters();
    t_unknown_decode();
    t_store_and_interlock();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule